// File: doc/BRIEF.md
# Jump Effective Address Sequencer

This block works out where a jump instruction goes and then loads the program counter with that address. It receives a 6-bit destination field. Bits [5:3] hold the addressing mode and bits [2:0] name one of eight 16-bit general registers. Register 7 is the program counter. The block holds the register file itself. It reads and updates that file as the mode requires. It fetches index words and pointer words through a single-port word-read interface.

A sequence starts with a one-cycle `start` pulse while the block is idle. The block then steps through a short state machine. While it does so, `busy` stays high, and new starts and register or flag loads from outside are ignored. Register mode cannot be a jump target. For that mode the block raises `illegal` and changes nothing. The condition flags sit next to the register file and are never touched by a sequence.

Memory reads use a valid/ready request channel and a response strobe. A request holds its address steady until `mem_ready` is seen with `mem_valid`. Only one request is outstanding at a time. The response arrives on `rsp_valid`, one or more cycles after the request was accepted. The block is always ready for the response, so there is no back-pressure on the response side.

Top module: `jump_ea_seq`

## Requirements
- R1: After reset all eight registers and the flags read 0, and `busy`, `done`, `illegal` and `mem_valid` are low.
- R2: Mode 0 (field bits [5:3] = 000) is rejected. `illegal` is high for exactly the one cycle after the start. No register changes, no memory request is made, and `done` stays low.
- R3: Mode 1 sets the PC to the value of the named register.
- R4: Mode 2 sets the PC to the old value of the named register, and that register gains 2. When the named register is the PC, the final PC equals its old value.
- R5: Mode 4 first lowers the named register by 2 and then sets the PC to the lowered value.
- R6: Mode 3 reads the word at the address held in the named register, adds 2 to that register, and jumps to the word read. When the named register is the PC, this is an absolute jump to the word that follows the instruction.
- R7: Mode 5 lowers the named register by 2, reads the word at the lowered address, and jumps to that word.
- R8: Mode 6 reads an index word at the current PC, and the PC is advanced by 2 when that read is accepted. It then jumps to the named register plus the index. For register 7 the base is the advanced PC.
- R9: Mode 7 reads the index word as in R8, then reads the word at register plus index, and jumps to that word.
- R10: The flags never change during or because of a sequence. A flag load while `busy` is high has no effect.
- R11: `done` is a one-cycle pulse. It comes in the first cycle in which the new PC can be read back, and `busy` is low in that cycle.
- R12: `mem_addr` stays stable while `mem_valid` is high and `mem_ready` is low. `mem_valid` is high only while `busy` is high. A `rsp_valid` that arrives while no read is awaited is ignored.
- R13: A `start` or register load while `busy` is high is ignored. All register arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sequence when idle |
| dst_field | input | 6 | Mode in [5:3], register number in [2:0] |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse once the new PC is in place |
| illegal | output | 1 | One-cycle pulse for a register-mode target |
| mem_valid | output | 1 | Read request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 16 | Read address, held while waiting for ready |
| rsp_valid | input | 1 | Read data valid strobe |
| rsp_data | input | 16 | Read data word |
| ld_en | input | 1 | Register load strobe, honoured when idle |
| ld_idx | input | 3 | Register number to load |
| ld_data | input | 16 | Register load value |
| peek_idx | input | 3 | Register number to observe |
| peek_data | output | 16 | Current value of the observed register |
| flag_ld | input | 1 | Flag load strobe, honoured when idle |
| flag_in | input | 4 | Flag load value |
| flags | output | 4 | Current condition flags |

## Verification
The assertions assume that memory answers only a request that has been accepted, and at most once per request. They also assume the answer never comes in the same cycle as the accepting handshake. The bench memory therefore keeps a single pending slot filled at the handshake and answers after a set latency of one or more cycles. Its ready line may drop at any time, and does so pseudo-randomly in the stalled runs. A stray response strobe is injected only while the block is idle. That stimulus checks the ignore rule at the ports and never breaks the assumption about awaited reads.

// File: rtl/jea_pkg.sv
package jea_pkg;

  localparam int unsigned MODE_W = 3;

  typedef enum logic [2:0] {
    M_REG         = 3'd0,
    M_DEF         = 3'd1,
    M_POSTINC     = 3'd2,
    M_POSTINC_DEF = 3'd3,
    M_PREDEC      = 3'd4,
    M_PREDEC_DEF  = 3'd5,
    M_INDEX       = 3'd6,
    M_INDEX_DEF   = 3'd7
  } amode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADJ,
    S_IDX,
    S_IDXW,
    S_RD,
    S_RDW,
    S_JUMP
  } st_e;

endpackage

// File: rtl/jea_regfile.sv
module jea_regfile #(
  parameter int unsigned W    = 16,
  parameter int unsigned NREG = 8,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ra_idx,
  input  logic [IW-1:0] rb_idx,
  output logic [W-1:0]  ra_data,
  output logic [W-1:0]  rb_data,
  output logic [W-1:0]  pc_data
);

  logic [W-1:0] regs [NREG];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          regs[g] <= '0;
        else if (we && (widx == IW'(g)))
          regs[g] <= wdata;
      end
    end
  endgenerate

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];
  assign pc_data = regs[NREG-1];

endmodule

// File: rtl/jea_agen.sv
module jea_agen #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] rn_val,
  input  logic [W-1:0] pc_val,
  input  logic [W-1:0] index_val,
  input  logic         dec,
  output logic [W-1:0] adj_val,
  output logic [W-1:0] sum_val,
  output logic [W-1:0] pc_inc
);

  localparam logic [W-1:0] STEP = W'(W / 8);

  assign adj_val = dec ? (rn_val - STEP) : (rn_val + STEP);
  assign sum_val = rn_val + index_val;
  assign pc_inc  = pc_val + STEP;

endmodule

// File: rtl/jea_ctrl.sv
module jea_ctrl
  import jea_pkg::*;
#(
  parameter int unsigned W   = 16,
  parameter int unsigned IW  = 3,
  localparam int unsigned DW = MODE_W + IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dst,
  input  logic [W-1:0]  rn_val,
  input  logic [W-1:0]  pc_val,
  input  logic [W-1:0]  adj_val,
  input  logic [W-1:0]  sum_val,
  input  logic [W-1:0]  pc_inc,
  input  logic          mem_ready,
  input  logic          rsp_valid,
  input  logic [W-1:0]  rsp_data,
  output logic [IW-1:0] rn_idx,
  output logic          adj_dec,
  output logic          busy,
  output logic          done,
  output logic          illegal,
  output logic          mem_valid,
  output logic [W-1:0]  mem_addr,
  output logic          int_we,
  output logic [IW-1:0] int_widx,
  output logic [W-1:0]  int_wdata
);

  localparam logic [IW-1:0] PC_IDX = '1;
  localparam logic [W-1:0]  STEP   = W'(W / 8);

  st_e           st, st_n;
  amode_e        mode_q;
  amode_e        mode_in;
  logic [IW-1:0] rn_q;
  logic [W-1:0]  addr_q, addr_n;
  logic          done_q, ill_q;
  logic          accept;

  assign mode_in = amode_e'(dst[DW-1:IW]);
  assign accept  = start && (st == S_IDLE);
  assign rn_idx  = (st == S_IDLE) ? dst[IW-1:0] : rn_q;
  assign adj_dec = (mode_q == M_PREDEC) || (mode_q == M_PREDEC_DEF);

  always_comb begin
    st_n      = st;
    addr_n    = addr_q;
    int_we    = 1'b0;
    int_widx  = rn_q;
    int_wdata = adj_val;
    case (st)
      S_IDLE: begin
        if (accept) begin
          case (mode_in)
            M_REG: st_n = S_IDLE;
            M_DEF: begin
              addr_n = rn_val;
              st_n   = S_JUMP;
            end
            M_POSTINC, M_POSTINC_DEF, M_PREDEC, M_PREDEC_DEF: st_n = S_ADJ;
            default: st_n = S_IDX;
          endcase
        end
      end
      S_ADJ: begin
        int_we    = 1'b1;
        int_widx  = rn_q;
        int_wdata = adj_val;
        addr_n    = adj_dec ? adj_val : rn_val;
        st_n      = mode_q[0] ? S_RD : S_JUMP;
      end
      S_IDX: begin
        if (mem_ready) begin
          int_we    = 1'b1;
          int_widx  = PC_IDX;
          int_wdata = pc_inc;
          st_n      = S_IDXW;
        end
      end
      S_IDXW: begin
        if (rsp_valid) begin
          addr_n = sum_val;
          st_n   = mode_q[0] ? S_RD : S_JUMP;
        end
      end
      S_RD: begin
        if (mem_ready) st_n = S_RDW;
      end
      S_RDW: begin
        if (rsp_valid) begin
          addr_n = rsp_data;
          st_n   = S_JUMP;
        end
      end
      S_JUMP: begin
        int_we    = 1'b1;
        int_widx  = PC_IDX;
        int_wdata = addr_q;
        st_n      = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      mode_q <= M_REG;
      rn_q   <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      st     <= st_n;
      addr_q <= addr_n;
      done_q <= (st == S_JUMP);
      ill_q  <= accept && (mode_in == M_REG);
      if (accept) begin
        mode_q <= mode_in;
        rn_q   <= dst[IW-1:0];
      end
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign illegal   = ill_q;
  assign mem_valid = (st == S_IDX) || (st == S_RD);
  assign mem_addr  = (st == S_IDX) ? pc_val : addr_q;

  a_r12_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

  a_r12_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);

  a_r11_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r2_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!done && !busy && !mem_valid));

  a_r8_pc_bump: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDX && mem_ready) |=> (pc_val == $past(pc_val) + STEP));

endmodule

// File: rtl/jump_ea_seq.sv
module jump_ea_seq
  import jea_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter int unsigned NREG   = 8,
  parameter int unsigned FLAG_W = 4,
  localparam int unsigned IW    = $clog2(NREG),
  localparam int unsigned DW    = MODE_W + IW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DW-1:0]     dst_field,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [W-1:0]      mem_addr,
  input  logic              rsp_valid,
  input  logic [W-1:0]      rsp_data,
  input  logic              ld_en,
  input  logic [IW-1:0]     ld_idx,
  input  logic [W-1:0]      ld_data,
  input  logic [IW-1:0]     peek_idx,
  output logic [W-1:0]      peek_data,
  input  logic              flag_ld,
  input  logic [FLAG_W-1:0] flag_in,
  output logic [FLAG_W-1:0] flags
);

  logic [IW-1:0]     rn_idx, int_widx, rf_widx;
  logic [W-1:0]      rn_val, pc_val, adj_val, sum_val, pc_inc;
  logic [W-1:0]      int_wdata, rf_wdata;
  logic              int_we, rf_we, adj_dec;
  logic [FLAG_W-1:0] flag_q;

  assign rf_we    = int_we || (ld_en && !busy);
  assign rf_widx  = int_we ? int_widx : ld_idx;
  assign rf_wdata = int_we ? int_wdata : ld_data;

  jea_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .widx    (rf_widx),
    .wdata   (rf_wdata),
    .ra_idx  (rn_idx),
    .rb_idx  (peek_idx),
    .ra_data (rn_val),
    .rb_data (peek_data),
    .pc_data (pc_val)
  );

  jea_agen #(.W(W)) u_agen (
    .rn_val    (rn_val),
    .pc_val    (pc_val),
    .index_val (rsp_data),
    .dec       (adj_dec),
    .adj_val   (adj_val),
    .sum_val   (sum_val),
    .pc_inc    (pc_inc)
  );

  jea_ctrl #(.W(W), .IW(IW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .dst       (dst_field),
    .rn_val    (rn_val),
    .pc_val    (pc_val),
    .adj_val   (adj_val),
    .sum_val   (sum_val),
    .pc_inc    (pc_inc),
    .mem_ready (mem_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rn_idx    (rn_idx),
    .adj_dec   (adj_dec),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .int_we    (int_we),
    .int_widx  (int_widx),
    .int_wdata (int_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= '0;
    else if (flag_ld && !busy)
      flag_q <= flag_in;
  end

  assign flags = flag_q;

  a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(flags));

  a_r13_no_outside_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !int_we) |-> !rf_we);

endmodule

// File: tb/jump_ea_seq_test.sv
module jump_ea_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  dst = '0;
  logic        busy, done, illegal, mem_valid;
  logic        mem_ready = 1'b1;
  logic [15:0] mem_addr;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_idx = '0;
  logic [15:0] ld_data = '0;
  logic [2:0]  peek_idx = '0;
  logic [15:0] peek_data;
  logic        flag_ld = 1'b0;
  logic [3:0]  flag_in = '0;
  logic [3:0]  flags;

  int n_checks = 0;
  int n_fail   = 0;

  logic [15:0] mregs [8];
  logic [3:0]  mflags = '0;
  logic [15:0] expq [$];

  logic        stall_en = 1'b0;
  int          lat_cfg  = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic        pend = 1'b0;
  logic [15:0] pend_addr = '0;
  int          lat_cnt = 0;
  logic        rsp_q = 1'b0;
  logic [15:0] rsp_dq = '0;
  logic        spur_v = 1'b0;
  logic [15:0] spur_d = '0;
  logic        live = 1'b0;

  always #2 clk = ~clk;

  assign rsp_valid = rsp_q | spur_v;
  assign rsp_data  = spur_v ? spur_d : rsp_dq;

  jump_ea_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dst_field(dst),
    .busy(busy), .done(done), .illegal(illegal),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .peek_idx(peek_idx), .peek_data(peek_data),
    .flag_ld(flag_ld), .flag_in(flag_in), .flags(flags)
  );

  function automatic logic [15:0] memw(input logic [15:0] a);
    return (a * 16'd3) ^ 16'h0F0F;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string mtag(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R6";
      3'd4: return "R5";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  // memory responder: one pending slot, latency lat_cfg+1 cycles
  always @(posedge clk) begin
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready <= stall_en ? lfsr[0] : 1'b1;
    rsp_q     <= 1'b0;
    if (pend) begin
      if (lat_cnt == 0) begin
        rsp_q  <= 1'b1;
        rsp_dq <= memw(pend_addr);
        pend   <= 1'b0;
      end else begin
        lat_cnt <= lat_cnt - 1;
      end
    end
    if (rst_n && mem_valid && mem_ready) begin
      pend      <= 1'b1;
      pend_addr <= mem_addr;
      lat_cnt   <= lat_cfg;
      if (expq.size() == 0) chk("R12 unexpected request", mem_addr, 16'hxxxx);
      else chk("R12 request address", mem_addr, expq.pop_front());
    end
  end

  // per-clock comparison against the model flags and handshake rule
  always @(negedge clk) begin
    if (live) begin
      chk("R10 flags", {12'd0, flags}, {12'd0, mflags});
      if (mem_valid && !busy) chk("R12 valid without busy", 16'd1, 16'd0);
    end
  end

  task automatic load_reg(input logic [2:0] i, input logic [15:0] v);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = i; ld_data = v;
    @(negedge clk);
    ld_en = 1'b0;
    mregs[i] = v;
  endtask

  task automatic load_flags(input logic [3:0] v);
    @(negedge clk);
    flag_ld = 1'b1; flag_in = v;
    @(posedge clk);
    #1 mflags = v;
    @(negedge clk);
    flag_ld = 1'b0;
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 8; i++) begin
      peek_idx = 3'(i);
      #1;
      chk(req, peek_data, mregs[i]);
    end
  endtask

  task automatic run_op(input logic [2:0] m, input logic [2:0] n, input bit meddle);
    logic [15:0] r, pc, idx, a, tgt;
    logic [2:0]  mreg;
    int          cnt;
    bit          exp_ill;
    string       tg;
    tg      = mtag(m);
    exp_ill = (m == 3'd0);
    r       = mregs[n];
    pc      = mregs[7];
    tgt     = '0;
    mreg    = (n == 3'd2) ? 3'd3 : 3'd2;
    case (m)
      3'd1: tgt = r;
      3'd2: begin tgt = r; mregs[n] = r + 16'd2; end
      3'd4: begin mregs[n] = r - 16'd2; tgt = r - 16'd2; end
      3'd3: begin expq.push_back(r); mregs[n] = r + 16'd2; tgt = memw(r); end
      3'd5: begin a = r - 16'd2; mregs[n] = a; expq.push_back(a); tgt = memw(a); end
      3'd6, 3'd7: begin
        expq.push_back(pc);
        idx = memw(pc);
        mregs[7] = pc + 16'd2;
        a = mregs[n] + idx;
        if (m == 3'd6) tgt = a;
        else begin expq.push_back(a); tgt = memw(a); end
      end
      default: ;
    endcase
    if (!exp_ill) mregs[7] = tgt;

    @(negedge clk);
    dst = {m, n}; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (meddle) begin
      start = 1'b1; dst = 6'o01;
      ld_en = 1'b1; ld_idx = mreg; ld_data = 16'hDEAD;
      flag_ld = 1'b1; flag_in = ~mflags;
      @(negedge clk);
      start = 1'b0; ld_en = 1'b0; flag_ld = 1'b0;
    end
    cnt = 0;
    while (!done && !illegal && cnt < 400) begin
      @(negedge clk);
      cnt++;
    end
    if (cnt >= 400) chk({tg, " timeout"}, 16'd0, 16'd1);
    if (exp_ill) begin
      chk("R2 illegal flag", {15'd0, illegal}, 16'd1);
      chk("R2 no done", {15'd0, done}, 16'd0);
    end else begin
      chk({tg, " done"}, {15'd0, done}, 16'd1);
      chk("R11 idle at done", {15'd0, busy}, 16'd0);
      chk({tg, " new pc at done"}, peek_pc(), tgt);
    end
    @(negedge clk);
    chk("R11 done single", {15'd0, done}, 16'd0);
    chk("R2 illegal single", {15'd0, illegal}, 16'd0);
    check_regs(tg);
    if (meddle) begin
      peek_idx = mreg;
      #1 chk("R13 load while busy", peek_data, mregs[mreg]);
    end
    chk("R12 all requests made", 16'(expq.size()), 16'd0);
    expq.delete();
  endtask

  function automatic logic [15:0] peek_pc();
    return uut.peek_data === uut.peek_data ? mregs_pc_read() : 16'hxxxx;
  endfunction

  function automatic logic [15:0] mregs_pc_read();
    return pc_seen;
  endfunction

  logic [15:0] pc_seen;
  always @(*) pc_seen = peek_data;

  initial begin
    peek_idx = 3'd7;
    for (int i = 0; i < 8; i++) mregs[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    live = 1'b1;
    chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 illegal", {15'd0, illegal}, 16'd0);
    chk("R1 mem_valid", {15'd0, mem_valid}, 16'd0);
    chk("R1 flags", {12'd0, flags}, 16'd0);
    check_regs("R1");
    peek_idx = 3'd7;

    load_reg(3'd0, 16'h0010);
    load_reg(3'd1, 16'h1000);
    load_reg(3'd2, 16'h2000);
    load_reg(3'd3, 16'h3000);
    load_reg(3'd4, 16'h4444);
    load_reg(3'd5, 16'h8000);
    load_reg(3'd6, 16'hFFFE);
    load_reg(3'd7, 16'h0200);
    load_flags(4'b1010);
    peek_idx = 3'd7;

    run_op(3'd0, 3'd3, 1'b0);
    peek_idx = 3'd7;
    run_op(3'd1, 3'd1, 1'b0);  peek_idx = 3'd7;
    run_op(3'd2, 3'd6, 1'b0);  peek_idx = 3'd7;
    run_op(3'd4, 3'd0, 1'b0);  peek_idx = 3'd7;
    run_op(3'd3, 3'd2, 1'b0);  peek_idx = 3'd7;
    run_op(3'd5, 3'd5, 1'b0);  peek_idx = 3'd7;
    run_op(3'd6, 3'd4, 1'b0);  peek_idx = 3'd7;
    run_op(3'd7, 3'd3, 1'b0);  peek_idx = 3'd7;
    run_op(3'd1, 3'd7, 1'b0);  peek_idx = 3'd7;
    run_op(3'd2, 3'd7, 1'b0);  peek_idx = 3'd7;
    run_op(3'd3, 3'd7, 1'b0);  peek_idx = 3'd7;
    run_op(3'd6, 3'd7, 1'b0);  peek_idx = 3'd7;
    run_op(3'd7, 3'd7, 1'b0);  peek_idx = 3'd7;
    run_op(3'd4, 3'd7, 1'b0);  peek_idx = 3'd7;

    stall_en = 1'b1;
    lat_cfg  = 2;
    load_flags(4'b0101);
    peek_idx = 3'd7;
    for (int k = 0; k < 3; k++) begin
      run_op(3'd3, 3'd1, 1'b1);  peek_idx = 3'd7;
      run_op(3'd5, 3'd4, 1'b1);  peek_idx = 3'd7;
      run_op(3'd6, 3'd7, 1'b1);  peek_idx = 3'd7;
      run_op(3'd7, 3'd0, 1'b1);  peek_idx = 3'd7;
      run_op(3'd1, 3'd6, 1'b1);  peek_idx = 3'd7;
      run_op(3'd0, 3'd7, 1'b0);  peek_idx = 3'd7;
    end

    // stray response while idle (R12)
    @(negedge clk);
    spur_v = 1'b1; spur_d = 16'h7777;
    @(negedge clk);
    spur_v = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 stray response busy", {15'd0, busy}, 16'd0);
    chk("R12 stray response done", {15'd0, done}, 16'd0);
    check_regs("R12");
    peek_idx = 3'd7;
    run_op(3'd2, 3'd5, 1'b0);

    live = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule